// File: doc/BRIEF.md
# PTP Event Timestamp Capture Unit

This unit sits beside one switch port and records when a precision-time event message crosses that port. For each direction, receive and transmit, the frame logic supplies a single-cycle strobe. With the strobe come the frame's destination MAC address, the 4-bit message type, the sequence ID and the 48-bit source identity. The unit also takes a free-running clock count from the time base. When a strobe qualifies, the unit stores the clock count, the identity and the sequence ID for that direction and raises a sticky interrupt flag.

A strobe qualifies only if two checks pass. The first is the role check: the port's role (master or slave) and the direction must match the message type. The second is the address check: the destination must match one of five individually enabled multicast addresses. Four of those addresses are fixed and one is programmable. A per-direction lock can hold the first capture until software clears the flag. Software loads the configuration word through a one-cycle write strobe and clears each flag with a one-cycle pulse.

Top module: `ptp_stamp_capture`

## Requirements
- R1: While reset is asserted and after it is released, both interrupt flags read 0 and every captured clock, identity and sequence output reads 0.
- R2: The configuration word `cfg_bits` has this layout: bit 0 is the role (1 = master), bit 1 enables the primary address, bits 2 to 4 enable alternate addresses 1 to 3, bit 5 enables the auxiliary address, bit 6 is the receive lock and bit 7 is the transmit lock. After reset the word is 8'hC2, which means slave, primary address only, and both locks on. The auxiliary address resets to 0.
- R3: Message type 0 is Sync and 1 is Delay_Req; every other type value is ignored. A master captures on a transmitted Sync and on a received Delay_Req. A slave captures on a transmitted Delay_Req and on a received Sync.
- R4: A strobe can capture only if its destination matches an enabled fixed address. The four fixed addresses are 01:00:5E:00:01:81 (primary, bit 1), 01:00:5E:00:01:82 (bit 2), 01:00:5E:00:01:83 (bit 3) and 01:00:5E:00:01:84 (bit 4). As an alternative, R5 applies.
- R5: The programmable auxiliary address, loaded from `cfg_aux_mac` on a configuration write, is accepted as a destination when bit 5 is set. It must match on all 48 bits.
- R6: A qualifying strobe in cycle N stores the clock count, identity and sequence ID of cycle N together and sets that direction's flag. The new values are visible from cycle N+1. Without a strobe, the stored values do not change.
- R7: When a direction's lock bit is set and its flag is already set, a qualifying strobe leaves that direction's stored values unchanged.
- R8: When the lock bit is clear, each qualifying strobe overwrites the stored values and the flag stays set.
- R9: A one-cycle clear pulse drops the flag in the next cycle and leaves the stored values unchanged. If a capture happens in the same cycle as the clear, the capture wins and the flag stays set. A strobe that the lock blocks does not count as a capture.
- R10: A configuration write takes effect for strobes in later cycles only. A strobe in the same cycle as the write is judged by the old configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bits | input | 8 | Role, address enables and locks (layout in R2) |
| cfg_aux_mac | input | 48 | Auxiliary address, loaded on `cfg_we` |
| time_count | input | CLK_W | Free-running clock count |
| rx_evt | input | 1 | Receive event strobe |
| rx_dst_mac | input | 48 | Destination MAC of received frame |
| rx_msg_type | input | 4 | Message type of received frame |
| rx_seq_id | input | SEQ_W | Sequence ID of received frame |
| rx_src_id | input | ID_W | Source identity of received frame |
| rx_irq_clr | input | 1 | Receive flag clear pulse |
| tx_evt | input | 1 | Transmit event strobe |
| tx_dst_mac | input | 48 | Destination MAC of transmitted frame |
| tx_msg_type | input | 4 | Message type of transmitted frame |
| tx_seq_id | input | SEQ_W | Sequence ID of transmitted frame |
| tx_src_id | input | ID_W | Source identity of transmitted frame |
| tx_irq_clr | input | 1 | Transmit flag clear pulse |
| rx_stamp | output | CLK_W | Captured receive clock count |
| rx_ident | output | ID_W | Captured receive source identity |
| rx_seq | output | SEQ_W | Captured receive sequence ID |
| rx_irq | output | 1 | Sticky receive capture flag |
| tx_stamp | output | CLK_W | Captured transmit clock count |
| tx_ident | output | ID_W | Captured transmit source identity |
| tx_seq | output | SEQ_W | Captured transmit sequence ID |
| tx_irq | output | 1 | Sticky transmit capture flag |

## Verification
A corrupted configuration register shows up on the first strobe after the corruption. A wrong role bit or address enable makes a flag rise for a message that should be ignored, or stay low for one that should be captured, in the very next cycle. A stuck or missing lock shows as captured values that change, or fail to change, one cycle after a second strobe. A flag that does not clear, or a clear that beats a capture, is visible on the flag output one cycle after the pulse. The bench sweeps every message type, every fixed address, the auxiliary address and two non-matching addresses, in both roles and both directions, so each of these faults appears within a few cycles of the case that triggers it.

// File: rtl/ptp_stamp_capture.sv
module ptp_stamp_capture #(
  parameter int CLK_W = 32,
  parameter int ID_W  = 48,
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_bits,
  input  logic [47:0]      cfg_aux_mac,
  input  logic [CLK_W-1:0] time_count,
  input  logic             rx_evt,
  input  logic [47:0]      rx_dst_mac,
  input  logic [3:0]       rx_msg_type,
  input  logic [SEQ_W-1:0] rx_seq_id,
  input  logic [ID_W-1:0]  rx_src_id,
  input  logic             rx_irq_clr,
  input  logic             tx_evt,
  input  logic [47:0]      tx_dst_mac,
  input  logic [3:0]       tx_msg_type,
  input  logic [SEQ_W-1:0] tx_seq_id,
  input  logic [ID_W-1:0]  tx_src_id,
  input  logic             tx_irq_clr,
  output logic [CLK_W-1:0] rx_stamp,
  output logic [ID_W-1:0]  rx_ident,
  output logic [SEQ_W-1:0] rx_seq,
  output logic             rx_irq,
  output logic [CLK_W-1:0] tx_stamp,
  output logic [ID_W-1:0]  tx_ident,
  output logic [SEQ_W-1:0] tx_seq,
  output logic             tx_irq
);
  localparam logic [7:0]  CFG_RESET = 8'b1100_0010;
  localparam logic [39:0] GROUP_PFX = 40'h01_00_5E_00_01;
  localparam logic [3:0]  MSG_SYNC  = 4'd0;
  localparam logic [3:0]  MSG_DREQ  = 4'd1;

  logic [7:0]  cfg_q;
  logic [47:0] aux_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
      aux_q <= '0;
    end else if (cfg_we) begin
      cfg_q <= cfg_bits;
      aux_q <= cfg_aux_mac;
    end
  end

  wire is_master = cfg_q[0];

  wire rx_fixed = (rx_dst_mac[47:8] == GROUP_PFX) &&
                  ((cfg_q[1] && rx_dst_mac[7:0] == 8'h81) ||
                   (cfg_q[2] && rx_dst_mac[7:0] == 8'h82) ||
                   (cfg_q[3] && rx_dst_mac[7:0] == 8'h83) ||
                   (cfg_q[4] && rx_dst_mac[7:0] == 8'h84));
  wire tx_fixed = (tx_dst_mac[47:8] == GROUP_PFX) &&
                  ((cfg_q[1] && tx_dst_mac[7:0] == 8'h81) ||
                   (cfg_q[2] && tx_dst_mac[7:0] == 8'h82) ||
                   (cfg_q[3] && tx_dst_mac[7:0] == 8'h83) ||
                   (cfg_q[4] && tx_dst_mac[7:0] == 8'h84));
  wire rx_addr_ok = rx_fixed || (cfg_q[5] && rx_dst_mac == aux_q);
  wire tx_addr_ok = tx_fixed || (cfg_q[5] && tx_dst_mac == aux_q);

  wire rx_kind_ok = rx_msg_type == (is_master ? MSG_DREQ : MSG_SYNC);
  wire tx_kind_ok = tx_msg_type == (is_master ? MSG_SYNC : MSG_DREQ);

  wire rx_take = rx_evt && rx_addr_ok && rx_kind_ok && !(cfg_q[6] && rx_irq);
  wire tx_take = tx_evt && tx_addr_ok && tx_kind_ok && !(cfg_q[7] && tx_irq);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_stamp <= '0;
      rx_ident <= '0;
      rx_seq   <= '0;
      rx_irq   <= 1'b0;
    end else if (rx_take) begin
      rx_stamp <= time_count;
      rx_ident <= rx_src_id;
      rx_seq   <= rx_seq_id;
      rx_irq   <= 1'b1;
    end else if (rx_irq_clr) begin
      rx_irq   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_stamp <= '0;
      tx_ident <= '0;
      tx_seq   <= '0;
      tx_irq   <= 1'b0;
    end else if (tx_take) begin
      tx_stamp <= time_count;
      tx_ident <= tx_src_id;
      tx_seq   <= tx_seq_id;
      tx_irq   <= 1'b1;
    end else if (tx_irq_clr) begin
      tx_irq   <= 1'b0;
    end
  end
endmodule

// File: rtl/ptp_stamp_capture_chk.sv
module ptp_stamp_capture_chk #(
  parameter int CLK_W = 32,
  parameter int ID_W  = 48,
  parameter int SEQ_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lock_rx,
  input logic             lock_tx,
  input logic [47:0]      aux_mac,
  input logic             rx_evt,
  input logic [47:0]      rx_dst_mac,
  input logic             rx_irq_clr,
  input logic [CLK_W-1:0] rx_stamp,
  input logic [ID_W-1:0]  rx_ident,
  input logic [SEQ_W-1:0] rx_seq,
  input logic             rx_irq,
  input logic             tx_evt,
  input logic             tx_irq_clr,
  input logic [CLK_W-1:0] tx_stamp,
  input logic [ID_W-1:0]  tx_ident,
  input logic [SEQ_W-1:0] tx_seq,
  input logic             tx_irq
);
  wire rx_foreign = (rx_dst_mac[47:8] != 40'h01_00_5E_00_01) && (rx_dst_mac != aux_mac);

  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> !rx_irq && !tx_irq);

  a_r6_rx_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_evt |=> $stable(rx_stamp) && $stable(rx_ident) && $stable(rx_seq));

  a_r6_tx_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_evt |=> $stable(tx_stamp) && $stable(tx_ident) && $stable(tx_seq));

  a_r6_rx_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> $past(rx_evt));

  a_r7_rx_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
    lock_rx && rx_irq |=> $stable(rx_stamp) && $stable(rx_ident) && $stable(rx_seq));

  a_r7_tx_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
    lock_tx && tx_irq |=> $stable(tx_stamp) && $stable(tx_ident) && $stable(tx_seq));

  a_r9_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq_clr && !rx_evt |=> !rx_irq);

  a_r9_tx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq_clr && !tx_evt |=> !tx_irq);

  a_r4_rx_foreign_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt && rx_foreign && !rx_irq_clr |=> $stable(rx_irq) && $stable(rx_stamp));
endmodule

bind ptp_stamp_capture ptp_stamp_capture_chk #(.CLK_W(CLK_W), .ID_W(ID_W), .SEQ_W(SEQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lock_rx(cfg_q[6]), .lock_tx(cfg_q[7]), .aux_mac(aux_q),
  .rx_evt(rx_evt), .rx_dst_mac(rx_dst_mac), .rx_irq_clr(rx_irq_clr),
  .rx_stamp(rx_stamp), .rx_ident(rx_ident), .rx_seq(rx_seq), .rx_irq(rx_irq),
  .tx_evt(tx_evt), .tx_irq_clr(tx_irq_clr),
  .tx_stamp(tx_stamp), .tx_ident(tx_ident), .tx_seq(tx_seq), .tx_irq(tx_irq)
);

// File: tb/ptp_stamp_capture_tb.sv
module ptp_stamp_capture_tb;
  localparam logic [47:0] AUX = 48'h02_11_22_33_44_55;
  localparam logic [47:0] PRI = 48'h01_00_5E_00_01_81;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_bits = '0;
  logic [47:0] cfg_aux_mac = '0;
  logic [31:0] time_count = '0;
  logic rx_evt = 1'b0, tx_evt = 1'b0, rx_irq_clr = 1'b0, tx_irq_clr = 1'b0;
  logic [47:0] rx_dst_mac = '0, tx_dst_mac = '0, rx_src_id = '0, tx_src_id = '0;
  logic [3:0] rx_msg_type = '0, tx_msg_type = '0;
  logic [15:0] rx_seq_id = '0, tx_seq_id = '0;
  logic [31:0] rx_stamp, tx_stamp;
  logic [47:0] rx_ident, tx_ident;
  logic [15:0] rx_seq, tx_seq;
  logic rx_irq, tx_irq;

  int checks = 0;
  int failures = 0;
  int n = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ptp_stamp_capture u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bits(cfg_bits), .cfg_aux_mac(cfg_aux_mac),
    .time_count(time_count),
    .rx_evt(rx_evt), .rx_dst_mac(rx_dst_mac), .rx_msg_type(rx_msg_type), .rx_seq_id(rx_seq_id),
    .rx_src_id(rx_src_id), .rx_irq_clr(rx_irq_clr),
    .tx_evt(tx_evt), .tx_dst_mac(tx_dst_mac), .tx_msg_type(tx_msg_type), .tx_seq_id(tx_seq_id),
    .tx_src_id(tx_src_id), .tx_irq_clr(tx_irq_clr),
    .rx_stamp(rx_stamp), .rx_ident(rx_ident), .rx_seq(rx_seq), .rx_irq(rx_irq),
    .tx_stamp(tx_stamp), .tx_ident(tx_ident), .tx_seq(tx_seq), .tx_irq(tx_irq)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic wcfg(input logic [7:0] bits, input logic [47:0] aux);
    cfg_bits = bits; cfg_aux_mac = aux; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clr(input bit d);
    if (d) tx_irq_clr = 1'b1; else rx_irq_clr = 1'b1;
    @(negedge clk);
    rx_irq_clr = 1'b0; tx_irq_clr = 1'b0;
  endtask

  task automatic drive(input bit d, input logic [47:0] mac, input logic [3:0] typ,
                       input logic [15:0] sq, input logic [47:0] id, input logic [31:0] ts);
    time_count = ts;
    if (d) begin
      tx_dst_mac = mac; tx_msg_type = typ; tx_seq_id = sq; tx_src_id = id; tx_evt = 1'b1;
    end else begin
      rx_dst_mac = mac; rx_msg_type = typ; rx_seq_id = sq; rx_src_id = id; rx_evt = 1'b1;
    end
  endtask

  task automatic send(input bit d, input logic [47:0] mac, input logic [3:0] typ,
                      input logic [15:0] sq, input logic [47:0] id, input logic [31:0] ts);
    drive(d, mac, typ, sq, id, ts);
    @(negedge clk);
    rx_evt = 1'b0; tx_evt = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!rx_irq && !tx_irq && rx_stamp == 0 && tx_seq == 0 && rx_ident == 0, "R1 during reset",
          {rx_irq, tx_irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!rx_irq && !tx_irq && rx_stamp == 0 && tx_stamp == 0 && rx_seq == 0 && tx_ident == 0,
          "R1 after reset", {rx_irq, tx_irq}, 0);

    // R2 defaults: slave, primary only, locks on
    send(0, 48'h01_00_5E_00_01_82, 4'd0, 16'h11, 48'h1, 32'd50);
    check(!rx_irq, "R2 alt1 disabled at reset", rx_irq, 0);
    send(0, AUX, 4'd0, 16'h12, 48'h1, 32'd51);
    check(!rx_irq, "R2 aux disabled at reset", rx_irq, 0);
    send(0, 48'h0, 4'd0, 16'h13, 48'h1, 32'd52);
    check(!rx_irq, "R2 aux address zero at reset and disabled", rx_irq, 0);
    send(0, PRI, 4'd0, 16'h21, 48'hAAAA_0000_0001, 32'd100);
    check(rx_irq && rx_stamp == 100 && rx_seq == 16'h21 && rx_ident == 48'hAAAA_0000_0001,
          "R2 R3 R6 slave rx Sync on primary", rx_stamp, 100);
    send(1, PRI, 4'd1, 16'h31, 48'hBBBB_0000_0001, 32'd200);
    check(tx_irq && tx_stamp == 200 && tx_seq == 16'h31 && tx_ident == 48'hBBBB_0000_0001,
          "R3 R6 slave tx Delay_Req", tx_stamp, 200);

    // R7 lock on by default
    send(0, PRI, 4'd0, 16'h22, 48'hAAAA_0000_0002, 32'd101);
    check(rx_irq && rx_stamp == 100 && rx_seq == 16'h21 && rx_ident == 48'hAAAA_0000_0001,
          "R7 rx locked", rx_stamp, 100);
    send(1, PRI, 4'd1, 16'h32, 48'hBBBB_0000_0002, 32'd201);
    check(tx_irq && tx_stamp == 200 && tx_seq == 16'h31, "R7 tx locked", tx_stamp, 200);

    // R9 clear keeps values; blocked strobe with clear: clear wins
    clr(0);
    check(!rx_irq && rx_stamp == 100 && rx_seq == 16'h21, "R9 rx clear keeps values", rx_irq, 0);
    drive(1, PRI, 4'd1, 16'h33, 48'h3, 32'd202);
    tx_irq_clr = 1'b1;
    @(negedge clk);
    tx_evt = 1'b0; tx_irq_clr = 1'b0;
    check(!tx_irq && tx_stamp == 200, "R9 locked strobe is not a capture", tx_stamp, 200);

    // R10 write in the same cycle as a strobe uses the old config
    drive(0, PRI, 4'd0, 16'h40, 48'h40, 32'd300);
    cfg_bits = 8'h3F; cfg_aux_mac = AUX; cfg_we = 1'b1;
    @(negedge clk);
    rx_evt = 1'b0; cfg_we = 1'b0;
    check(rx_irq && rx_stamp == 300, "R10 strobe judged by old slave config", rx_stamp, 300);
    clr(0);
    send(0, PRI, 4'd0, 16'h41, 48'h41, 32'd301);
    check(!rx_irq, "R10 new master config ignores rx Sync", rx_irq, 0);

    // R8 unlocked overwrite (master, all enables, locks off)
    send(0, PRI, 4'd1, 16'h50, 48'h50, 32'd400);
    send(0, PRI, 4'd1, 16'h51, 48'h51, 32'd401);
    check(rx_irq && rx_stamp == 401 && rx_seq == 16'h51 && rx_ident == 48'h51,
          "R8 rx overwrite", rx_stamp, 401);
    send(1, PRI, 4'd0, 16'h52, 48'h52, 32'd402);
    send(1, PRI, 4'd0, 16'h53, 48'h53, 32'd403);
    check(tx_irq && tx_stamp == 403 && tx_seq == 16'h53, "R8 tx overwrite", tx_stamp, 403);

    // R9 capture beats clear
    drive(0, PRI, 4'd1, 16'h60, 48'h60, 32'd500);
    rx_irq_clr = 1'b1;
    @(negedge clk);
    rx_evt = 1'b0; rx_irq_clr = 1'b0;
    check(rx_irq && rx_stamp == 500, "R9 capture wins over clear", rx_stamp, 500);

    // R3 R4 R5 sweep: role x direction x type x address
    for (int m = 0; m < 2; m++) begin
      wcfg({2'b00, 5'b11111, m[0]}, AUX);
      for (int d = 0; d < 2; d++) begin
        for (int t = 0; t < 16; t++) begin
          for (int a = 0; a < 7; a++) begin
            logic [47:0] mac;
            bit exp;
            logic [31:0] ts;
            if (a < 4) mac = PRI + 48'(a);
            else if (a == 4) mac = AUX;
            else if (a == 5) mac = PRI + 48'd4 + 48'd0 + 48'h0 + 48'd0 + 48'd0 + 48'd0 + 48'd0 + 48'd0 + 48'd0 + 48'd0 + 48'd0 + 48'd0 + 48'd0 + 48'd4;
            else mac = AUX ^ 48'h0100_0000_0000;
            exp = (a < 5) && (t == ((d == 1) ? (m == 1 ? 0 : 1) : (m == 1 ? 1 : 0)));
            n++;
            ts = 32'(n * 7 + 3);
            clr(d[0]);
            send(d[0], mac, t[3:0], 16'(n), {16'hC0DE, 32'(n)}, ts);
            if (d == 0) begin
              if (exp) check(rx_irq && rx_stamp == ts && rx_seq == 16'(n) && rx_ident == {16'hC0DE, 32'(n)},
                             "R3 R4 R5 rx sweep capture", rx_stamp, ts);
              else check(!rx_irq, "R3 R4 R5 rx sweep ignore", rx_irq, 0);
            end else begin
              if (exp) check(tx_irq && tx_stamp == ts && tx_seq == 16'(n) && tx_ident == {16'hC0DE, 32'(n)},
                             "R3 R4 R5 tx sweep capture", tx_stamp, ts);
              else check(!tx_irq, "R3 R4 R5 tx sweep ignore", tx_irq, 0);
            end
          end
        end
      end
    end

    // R4 each fixed address honours its own enable bit
    for (int a = 0; a < 4; a++) begin
      wcfg(8'h3E & ~(8'h02 << a), AUX);
      clr(0);
      send(0, PRI + 48'(a), 4'd0, 16'h70, 48'h70, 32'd700);
      check(!rx_irq, "R4 disabled fixed address ignored", rx_irq, 0);
    end
    wcfg(8'h1E, AUX);
    clr(0);
    send(0, AUX, 4'd0, 16'h71, 48'h71, 32'd701);
    check(!rx_irq, "R5 aux ignored when its enable is clear", rx_irq, 0);

    done = 1'b1;
    report();
  end
endmodule